// File: doc/BRIEF.md
# Ethernet Transmit Retry Controller

This block sequences one Ethernet frame transmission through an external register access engine and recovers when a send stalls or fails. A host pulses `start` with a frame length. The controller then issues a fixed series of engine commands. It forces a reset of the transmit logic, clears the completion flags and loads the buffer pointers. It writes a zero control byte, has the engine stream the payload and raises the transmit request.

After the request, the controller reads the interrupt flag register until a completion or error flag appears. The number of reads has a fixed bound. If the send did not finish cleanly, the controller drops the request and reads back the seven-byte transmit status vector that follows the frame in the buffer. It starts another attempt only when the error flag is set and the vector reports a late collision. Retries reuse the payload already in the buffer. A single-cycle `done` pulse carries a status code.

The engine handles one command at a time. The controller holds a command on `cmd_*` until `eng_done` pulses, and takes read data from `eng_rdata` in that same cycle.

Top module: `eth_tx_retry_ctrl`

## Requirements
- R1: After reset, `busy`, `done` and `cmd_valid` are low, and nothing is issued until a start is accepted.
- R2: When the controller is idle, a `start` pulse captures `frame_len` and begins an attempt. Every attempt opens with the same three commands: set bit 0x80 at address 0x1F, clear bit 0x80 at address 0x1F, then clear mask 0x0A at address 0x1C.
- R3: The first attempt then issues four commands in order. It writes 16-bit register 0x02 with TX_START and 16-bit register 0x06 with TX_START+len. It then writes one buffer byte of 0x00 and streams the payload with data = len. The transmit request follows as a set of bit 0x08 at 0x1F.
- R4: After the request, the controller reads 0x1C repeatedly. It stops on the first read with bit 3 (done) or bit 1 (error) set, or after POLL_LIMIT reads that all returned zero, which is a timeout.
- R5: After polling, the controller reads 0x1C once more. If bit 1 of that read is clear and no timeout occurred, it finishes with status 0 (success).
- R6: Otherwise it clears bit 0x08 at 0x1F and writes register 0x00 with TX_START+len+1. It then reads seven buffer bytes and reads 0x1C once more.
- R7: A new attempt starts only when bit 1 of that last 0x1C read is set and bit 5 of status byte 3 (the fourth byte read) is set, and fewer than MAX_RETRY retries have been made. A retry skips the four load commands of R3.
- R8: When no retry is taken, the status code is chosen in this priority: 3 if the error and late-collision conditions both held (retry limit reached), otherwise 1 if polling timed out, otherwise 2 (error without collision).
- R9: A `start` while busy is ignored. The length captured at the first start stays in use, and no second run follows.
- R10: Each command stays valid and unchanged until `eng_done`. Operation codes are: 0 register read, 1 16-bit register write, 2 bit set, 3 bit clear, 4 single buffer byte write, 5 payload stream, 6 buffer byte read. Unused address and data fields are zero.
- R11: `done` is high for exactly one cycle per accepted start, in the cycle after the final response. `busy` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transmission (ignored while busy) |
| frame_len | input | LEN_W | Payload length, captured on an accepted start |
| busy | output | 1 | A transmission is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 error, 3 retry limit; valid with done |
| cmd_valid | output | 1 | Engine command present |
| cmd_op | output | 3 | Engine operation code |
| cmd_addr | output | 5 | Register address |
| cmd_data | output | PTR_W | Write data, bit mask or length |
| eng_done | input | 1 | Engine finished the current command |
| eng_rdata | input | 8 | Read data, valid with eng_done |

## Verification
Two decisions can land on the same flag read. One read can show both the done flag and the error flag. The error flag and the late-collision bit can also both hold when no retries are left. The bench builds both cases on purpose. A poll response of 0x0A must still take the failure path with status 2, because success requires the error flag to be clear. A run where every attempt reports a late collision must stop after exactly MAX_RETRY retries with status 3. The length capture is also tested against a start that arrives mid-run. The bench replays the expected command stream from the requirements and compares it command by command. The read-pointer value on the failure path must come from the first length, not the second.

// File: rtl/txr_pkg.sv
package txr_pkg;

    typedef enum logic [2:0] {
        OP_RREG   = 3'd0,
        OP_WREG16 = 3'd1,
        OP_BSET   = 3'd2,
        OP_BCLR   = 3'd3,
        OP_WBUF1  = 3'd4,
        OP_WBUFN  = 3'd5,
        OP_RBUF   = 3'd6
    } eng_op_e;

    typedef enum logic [1:0] {
        TX_OK          = 2'd0,
        TX_TIMEOUT     = 2'd1,
        TX_ERROR       = 2'd2,
        TX_RETRY_LIMIT = 2'd3
    } tx_status_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RST_SET,
        S_RST_CLR,
        S_FLAG_CLR,
        S_WPTR,
        S_ENDPTR,
        S_CTRLB,
        S_PAYLOAD,
        S_REQ,
        S_POLL,
        S_RECHECK,
        S_REQ_CLR,
        S_RDPTR,
        S_TSV,
        S_ERRCHK
    } txr_state_e;

    localparam logic [4:0] REG_CTRL  = 5'h1F;
    localparam logic [4:0] REG_FLAGS = 5'h1C;
    localparam logic [4:0] REG_WPTR  = 5'h02;
    localparam logic [4:0] REG_ENDP  = 5'h06;
    localparam logic [4:0] REG_RDPTR = 5'h00;

    localparam logic [7:0] BIT_TXRST = 8'h80;
    localparam logic [7:0] BIT_TXREQ = 8'h08;
    localparam logic [7:0] FLG_DONE  = 8'h08;
    localparam logic [7:0] FLG_ERR   = 8'h02;

endpackage

// File: rtl/txr_poll_counter.sv
module txr_poll_counter #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic inc,
    output logic last
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign last = (cnt_q == W'(LIMIT - 1));

    // R4: the controller never counts past the final allowed poll
    a_r4_no_inc_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !last);

    a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < W'(LIMIT));

endmodule

// File: rtl/txr_tsv_capture.sv
module txr_tsv_capture #(
    parameter int TSV_BYTES = 7,
    parameter int LATE_BYTE = 3,
    parameter int LATE_BIT  = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       strobe,
    input  logic [7:0] byte_in,
    output logic       last,
    output logic       late
);
    localparam int IW = $clog2(TSV_BYTES);

    logic [IW-1:0] idx_d, idx_q;
    logic          late_d, late_q;

    always_comb begin
        idx_d  = idx_q;
        late_d = late_q;
        if (clear) begin
            idx_d  = '0;
            late_d = 1'b0;
        end else if (strobe) begin
            idx_d = idx_q + IW'(1);
            if (idx_q == IW'(LATE_BYTE))
                late_d = |(byte_in & (8'h01 << LATE_BIT));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            late_q <= 1'b0;
        end else begin
            idx_q  <= idx_d;
            late_q <= late_d;
        end
    end

    assign last = (idx_q == IW'(TSV_BYTES - 1));
    assign late = late_q;

    // R6: exactly TSV_BYTES bytes are read per vector
    a_r6_tsv_bound: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> idx_q < IW'(TSV_BYTES));

endmodule

// File: rtl/txr_cmd_map.sv
module txr_cmd_map
    import txr_pkg::*;
#(
    parameter int LEN_W    = 11,
    parameter int PTR_W    = 16,
    parameter int TX_START = 'h1A00
) (
    input  txr_state_e        state,
    input  logic [LEN_W-1:0]  len,
    output eng_op_e           op,
    output logic [4:0]        addr,
    output logic [PTR_W-1:0]  data
);
    localparam logic [PTR_W-1:0] BASE = PTR_W'(TX_START);

    logic [PTR_W-1:0] end_ptr;
    assign end_ptr = BASE + PTR_W'(len);

    always_comb begin
        op   = OP_RREG;
        addr = '0;
        data = '0;
        case (state)
            S_RST_SET:  begin op = OP_BSET;   addr = REG_CTRL;  data = PTR_W'(BIT_TXRST); end
            S_RST_CLR:  begin op = OP_BCLR;   addr = REG_CTRL;  data = PTR_W'(BIT_TXRST); end
            S_FLAG_CLR: begin op = OP_BCLR;   addr = REG_FLAGS; data = PTR_W'(FLG_DONE | FLG_ERR); end
            S_WPTR:     begin op = OP_WREG16; addr = REG_WPTR;  data = BASE; end
            S_ENDPTR:   begin op = OP_WREG16; addr = REG_ENDP;  data = end_ptr; end
            S_CTRLB:    begin op = OP_WBUF1; end
            S_PAYLOAD:  begin op = OP_WBUFN;  data = PTR_W'(len); end
            S_REQ:      begin op = OP_BSET;   addr = REG_CTRL;  data = PTR_W'(BIT_TXREQ); end
            S_POLL:     begin op = OP_RREG;   addr = REG_FLAGS; end
            S_RECHECK:  begin op = OP_RREG;   addr = REG_FLAGS; end
            S_REQ_CLR:  begin op = OP_BCLR;   addr = REG_CTRL;  data = PTR_W'(BIT_TXREQ); end
            S_RDPTR:    begin op = OP_WREG16; addr = REG_RDPTR; data = end_ptr + PTR_W'(1); end
            S_TSV:      begin op = OP_RBUF; end
            S_ERRCHK:   begin op = OP_RREG;   addr = REG_FLAGS; end
            default:    begin op = OP_RREG; end
        endcase
    end

endmodule

// File: rtl/eth_tx_retry_ctrl.sv
module eth_tx_retry_ctrl
    import txr_pkg::*;
#(
    parameter int LEN_W      = 11,
    parameter int PTR_W      = 16,
    parameter int TX_START   = 'h1A00,
    parameter int POLL_LIMIT = 1000,
    parameter int MAX_RETRY  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] frame_len,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic [4:0]       cmd_addr,
    output logic [PTR_W-1:0] cmd_data,
    input  logic             eng_done,
    input  logic [7:0]       eng_rdata
);
    localparam int RW = $clog2(MAX_RETRY + 1);

    typedef struct packed {
        txr_state_e       st;
        logic [LEN_W-1:0] len;
        logic [RW-1:0]    retries;
        logic             timed_out;
        logic             done;
        tx_status_e       status;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        st: S_IDLE, len: '0, retries: '0, timed_out: 1'b0,
        done: 1'b0, status: TX_OK
    };

    ctrl_t r_d, r_q;

    logic    poll_clear, poll_inc, poll_last;
    logic    tsv_clear, tsv_strobe, tsv_last, tsv_late;
    logic    flag_hit, err_flag, late_hit;
    eng_op_e op_w;

    assign flag_hit = (eng_rdata & (FLG_DONE | FLG_ERR)) != 8'h00;
    assign err_flag = (eng_rdata & FLG_ERR) != 8'h00;
    assign late_hit = err_flag && tsv_late;

    always_comb begin
        r_d        = r_q;
        r_d.done   = 1'b0;
        poll_clear = 1'b0;
        poll_inc   = 1'b0;
        tsv_clear  = 1'b0;
        tsv_strobe = 1'b0;
        if (r_q.st == S_IDLE) begin
            if (start) begin
                r_d.st        = S_RST_SET;
                r_d.len       = frame_len;
                r_d.retries   = '0;
                r_d.timed_out = 1'b0;
            end
        end else if (eng_done) begin
            case (r_q.st)
                S_RST_SET:  r_d.st = S_RST_CLR;
                S_RST_CLR:  r_d.st = S_FLAG_CLR;
                S_FLAG_CLR: r_d.st = (r_q.retries == '0) ? S_WPTR : S_REQ;
                S_WPTR:     r_d.st = S_ENDPTR;
                S_ENDPTR:   r_d.st = S_CTRLB;
                S_CTRLB:    r_d.st = S_PAYLOAD;
                S_PAYLOAD:  r_d.st = S_REQ;
                S_REQ: begin
                    poll_clear = 1'b1;
                    r_d.st     = S_POLL;
                end
                S_POLL: begin
                    if (flag_hit) begin
                        r_d.st = S_RECHECK;
                    end else if (poll_last) begin
                        r_d.timed_out = 1'b1;
                        r_d.st        = S_RECHECK;
                    end else begin
                        poll_inc = 1'b1;
                    end
                end
                S_RECHECK: begin
                    if (!err_flag && !r_q.timed_out) begin
                        r_d.st     = S_IDLE;
                        r_d.done   = 1'b1;
                        r_d.status = TX_OK;
                    end else begin
                        r_d.st = S_REQ_CLR;
                    end
                end
                S_REQ_CLR:  r_d.st = S_RDPTR;
                S_RDPTR: begin
                    tsv_clear = 1'b1;
                    r_d.st    = S_TSV;
                end
                S_TSV: begin
                    tsv_strobe = 1'b1;
                    if (tsv_last)
                        r_d.st = S_ERRCHK;
                end
                S_ERRCHK: begin
                    if (late_hit && (r_q.retries < RW'(MAX_RETRY))) begin
                        r_d.retries   = r_q.retries + RW'(1);
                        r_d.timed_out = 1'b0;
                        r_d.st        = S_RST_SET;
                    end else begin
                        r_d.st   = S_IDLE;
                        r_d.done = 1'b1;
                        if (late_hit)
                            r_d.status = TX_RETRY_LIMIT;
                        else if (r_q.timed_out)
                            r_d.status = TX_TIMEOUT;
                        else
                            r_d.status = TX_ERROR;
                    end
                end
                default: r_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= CTRL_RST;
        else
            r_q <= r_d;
    end

    txr_poll_counter #(
        .LIMIT (POLL_LIMIT)
    ) u_poll (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (poll_clear),
        .inc   (poll_inc),
        .last  (poll_last)
    );

    txr_tsv_capture #(
        .TSV_BYTES (7),
        .LATE_BYTE (3),
        .LATE_BIT  (5)
    ) u_tsv (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tsv_clear),
        .strobe  (tsv_strobe),
        .byte_in (eng_rdata),
        .last    (tsv_last),
        .late    (tsv_late)
    );

    txr_cmd_map #(
        .LEN_W    (LEN_W),
        .PTR_W    (PTR_W),
        .TX_START (TX_START)
    ) u_map (
        .state (r_q.st),
        .len   (r_q.len),
        .op    (op_w),
        .addr  (cmd_addr),
        .data  (cmd_data)
    );

    assign cmd_op    = op_w;
    assign cmd_valid = (r_q.st != S_IDLE);
    assign busy      = (r_q.st != S_IDLE);
    assign done      = r_q.done;
    assign status    = r_q.status;

    // R10: a command is held unchanged until the engine completes it
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !eng_done) |=> (cmd_valid && $stable(cmd_op)
                                      && $stable(cmd_addr) && $stable(cmd_data)));

    // R11: done never lasts more than one cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: a start while busy does not end or restart the run early
    a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> (busy || done));

    // R2: a start in idle is always accepted
    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    // R7: retry count never exceeds its limit
    a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.retries <= RW'(MAX_RETRY));

    // R5: a success report follows a final flag read with the error bit clear
    a_r5_ok_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd0) |-> !$past(eng_rdata[1]));

endmodule

// File: tb/eth_tx_retry_ctrl_bench.sv
module eth_tx_retry_ctrl_bench;

    localparam int P     = 12;
    localparam int MAXR  = 3;
    localparam int TXS   = 'h1A00;
    localparam int LEN_W = 11;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [LEN_W-1:0] frame_len = '0;
    logic             busy, done, cmd_valid;
    logic [1:0]       status;
    logic [2:0]       cmd_op;
    logic [4:0]       cmd_addr;
    logic [15:0]      cmd_data;
    logic             eng_done = 1'b0;
    logic [7:0]       eng_rdata = 8'h00;

    always #2 clk = ~clk;

    eth_tx_retry_ctrl #(
        .LEN_W      (LEN_W),
        .PTR_W      (16),
        .TX_START   (TXS),
        .POLL_LIMIT (P),
        .MAX_RETRY  (MAXR)
    ) u_eth_tx_retry_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .frame_len (frame_len),
        .busy      (busy),
        .done      (done),
        .status    (status),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .eng_done  (eng_done),
        .eng_rdata (eng_rdata)
    );

    int checks = 0;
    int errors = 0;

    int    q_op[$];
    int    q_addr[$];
    int    q_data[$];
    string q_tag[$];

    int att_z[8];
    int att_f[8];
    int att_l[8];
    int attempt = -1;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(int op, int addr, int data, string tag);
        q_op.push_back(op);
        q_addr.push_back(addr);
        q_data.push_back(data);
        q_tag.push_back(tag);
    endtask

    task automatic set_att(int i, int z, int f, int l);
        att_z[i] = z;
        att_f[i] = f;
        att_l[i] = l;
    endtask

    // behavioural model: expected command stream and final status
    task automatic model(int len, output int st);
        int z, n, used, e_r, e_e;
        bit timed, err_late;
        st = -1;
        for (int a = 0; a < 8; a++) begin
            push(2, 'h1F, 'h80, "R2");
            push(3, 'h1F, 'h80, "R2");
            push(3, 'h1C, 'h0A, "R2");
            if (a == 0) begin
                push(1, 'h02, TXS, "R3");
                push(1, 'h06, TXS + len, "R3");
                push(4, 0, 0, "R3");
                push(5, 0, len, "R3");
            end
            push(2, 'h1F, 'h08, (a == 0) ? "R3" : "R7");
            z     = att_z[a];
            timed = (z >= P);
            n     = timed ? P : z + 1;
            for (int i = 0; i < n; i++) push(0, 'h1C, 0, "R4");
            push(0, 'h1C, 0, "R5");
            used = n + 1;
            e_r  = (z >= used) ? 0 : att_f[a];
            if (((e_r & 2) == 0) && !timed) begin
                st = 0;
                return;
            end
            push(3, 'h1F, 'h08, "R6");
            push(1, 'h00, TXS + len + 1, "R6");
            for (int i = 0; i < 7; i++) push(6, 0, 0, "R6");
            push(0, 'h1C, 0, "R6");
            e_e      = (z >= used + 1) ? 0 : att_f[a];
            err_late = ((e_e & 2) != 0) && (att_l[a] != 0);
            if (!(err_late && a < MAXR)) begin
                st = err_late ? 3 : (timed ? 1 : 2);
                return;
            end
        end
    endtask

    // engine model: accepts a command, answers two cycles later
    initial begin
        bit pending;
        int cd, zeros_left, cur_flag, cur_late, rb_idx, resp;
        string tg;
        pending = 0; cd = 0; zeros_left = 0; cur_flag = 0; cur_late = 0; rb_idx = 0; resp = 0;
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (pending) begin
                if (cd == 0) begin
                    eng_done  = 1'b1;
                    eng_rdata = 8'(resp);
                    pending   = 0;
                end else begin
                    cd--;
                end
            end else if (rst_n && cmd_valid) begin
                if (q_op.size() == 0) begin
                    check("R10", "unexpected command op", int'(cmd_op), 7);
                end else begin
                    tg = q_tag.pop_front();
                    check(tg, "cmd op",   int'(cmd_op),   q_op.pop_front());
                    check(tg, "cmd addr", int'(cmd_addr), q_addr.pop_front());
                    check(tg, "cmd data", int'(cmd_data), q_data.pop_front());
                end
                resp = 0;
                if (cmd_op == 3'd2 && cmd_addr == 5'h1F && cmd_data == 16'h0080) begin
                    if (attempt < 7) attempt++;
                    zeros_left = att_z[attempt];
                    cur_flag   = att_f[attempt];
                    cur_late   = att_l[attempt];
                end
                if (cmd_op == 3'd0 && cmd_addr == 5'h1C) begin
                    if (zeros_left > 0) zeros_left--;
                    else resp = cur_flag;
                end
                if (cmd_op == 3'd1 && cmd_addr == 5'h00) rb_idx = 0;
                if (cmd_op == 3'd6) begin
                    resp = (rb_idx == 3 && cur_late != 0) ? 'h20 : 'h00;
                    rb_idx++;
                end
                pending = 1;
                cd      = 1;
            end
        end
    end

    task automatic run_case(string name, int len, int late_len);
        int exp_st;
        int cyc;
        bit seen;
        model(len, exp_st);
        attempt = -1;
        @(negedge clk);
        start     = 1'b1;
        frame_len = LEN_W'(len);
        seen = 0;
        cyc  = 0;
        while (cyc < 20000) begin
            @(negedge clk);
            cyc++;
            start = 1'b0;
            if (cyc == 10 && late_len >= 0) begin
                start     = 1'b1;
                frame_len = LEN_W'(late_len);
            end
            if (done) begin
                seen = 1;
                break;
            end
        end
        start = 1'b0;
        check("R11", {name, " done seen"}, int'(seen), 1);
        check("R8",  {name, " status"}, int'(status), exp_st);
        check("R11", {name, " busy low at done"}, int'(busy), 0);
        @(negedge clk);
        check("R11", {name, " done one cycle"}, int'(done), 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (cmd_valid || done) check("R9", {name, " no activity after done"}, 1, 0);
        end
        check("R10", {name, " all commands issued"}, q_op.size(), 0);
        q_op.delete(); q_addr.delete(); q_data.delete(); q_tag.delete();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) set_att(i, 0, 'h08, 0);
        repeat (3) @(negedge clk);
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "cmd_valid idle", int'(cmd_valid), 0);
        check("R1", "busy idle", int'(busy), 0);

        // R2 R3 R4 R5: clean send after three idle polls
        set_att(0, 3, 'h08, 0);
        run_case("clean", 64, -1);

        // R6 R8: error without collision
        set_att(0, 0, 'h02, 0);
        run_case("error", 20, -1);

        // R4 R8: timeout after POLL_LIMIT reads
        set_att(0, 1000, 'h00, 0);
        run_case("timeout", 30, -1);

        // R4: flag on the last allowed poll still succeeds
        set_att(0, P - 1, 'h08, 0);
        run_case("last_poll", 5, -1);

        // R5 R8: done and error flags in the same read
        set_att(0, 1, 'h0A, 0);
        run_case("both_flags", 40, -1);

        // R7: one late collision, then success without reload
        set_att(0, 0, 'h02, 1);
        set_att(1, 2, 'h08, 0);
        run_case("one_retry", 48, -1);

        // R7 R8: late collision every attempt hits the retry limit
        for (int i = 0; i < 8; i++) set_att(i, 0, 'h02, 1);
        run_case("retry_limit", 10, -1);

        // R7: late bit without error flag (timeout) does not retry
        set_att(0, 1000, 'h00, 1);
        run_case("late_no_err", 12, -1);

        // R9: start while busy ignored, first length kept
        set_att(0, 0, 'h02, 1);
        set_att(1, 0, 'h08, 0);
        run_case("busy_start", 33, 99);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule